// File: doc/BRIEF.md
# PCM Time-Slot Voice Port

This block is the serial voice-data port of a telephony codec. A master bit clock drives it. A frame-sync input marks each frame. Within a frame the port places one 8-bit voice slot. In that slot it shifts a transmit byte out on a drivable transmit pin and shifts a receive byte in from the receive pin. Outside that slot the transmit pin is not driven. The pad combines `dx_o` with `dx_oe_o` to form the tri-state pin.

The core side is a parallel byte on each path. The transmit byte is taken in once per frame, at the frame start, and `tx_take_o` marks that moment. The receive byte is presented with a one-cycle `rx_valid_o` strobe once all eight bits have arrived.

Static control inputs set the following:
- the frame-sync timing relationship;
- a two-slot or gapped-slot layout;
- which of the two slots is used;
- a transfer enable;
- a companded-coding flag, which is the only case in which the second slot may be chosen.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `dx_oe_o`, `rx_valid_o` and `tx_take_o` are low and `rx_byte_o` is 0.
- R2: With `mode_i` = 00 (direct), the rising clock edge that first samples `fs_i` high begins frame bit 0. Every later edge begins the next bit. Slot bits go out MSB first, with `dx_oe_o` high for exactly the 8 slot bits, and the data changes just after rising edges.
- R3: With `mode_i` = 10 or 11 (late start), frame bit 0 begins one clock later than in direct mode.
- R4: With `mode_i` = 01 (inverted edges), `dx_o` and `dx_oe_o` change at the falling edge in the middle of each bit, which is half a bit after direct mode. The received bit is sampled at the rising edge that ends it.
- R5: With `fmt_i` = 0, the second slot occupies frame bits 8 to 15.
- R6: With `fmt_i` = 1, the second slot occupies frame bits 10 to 17, which leaves bits 8 and 9 as an idle gap.
- R7: The slot is chosen as follows:
  - When `comp_i` = 1, `slot_sel_i` = 1 picks the second slot and `slot_sel_i` = 0 picks the first slot (bits 0 to 7).
  - When `comp_i` = 0, the first slot is used whatever `slot_sel_i` is.
- R8: With `en_i` low, `dx_oe_o` stays low and no `rx_valid_o` strobe occurs.
- R9: Received bits are assembled MSB first. In direct and late-start modes each bit is sampled at the falling edge in the middle of the bit. `rx_valid_o` is high for one cycle, in the cycle after the eighth slot bit, and `rx_byte_o` holds the byte from then on.
- R10: `tx_byte_i` is captured at the edge that starts frame bit 0, and `tx_take_o` is high during bit 0. Changes to `tx_byte_i` later in the frame do not alter the bits sent.
- R11: Only a rising edge of `fs_i` starts a frame. Holding `fs_i` high for many cycles starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master bit clock |
| rst | input | 1 | synchronous active-high reset |
| fs_i | input | 1 | frame sync; its rising edge marks a frame |
| mode_i | input | 2 | timing relationship: 00 direct, 01 inverted edges, 1x late start |
| fmt_i | input | 1 | 0 = adjacent slots, 1 = two-bit gap before the second slot |
| slot_sel_i | input | 1 | 1 = second slot (honoured only when companded) |
| en_i | input | 1 | voice transfer enable |
| comp_i | input | 1 | companded coding active |
| tx_byte_i | input | 8 | transmit byte, taken at frame start |
| tx_take_o | output | 1 | high in the cycle in which the transmit byte was taken |
| dx_o | output | 1 | transmit serial data |
| dx_oe_o | output | 1 | transmit pin drive enable (low = high impedance) |
| dr_i | input | 1 | receive serial data |
| rx_byte_o | output | 8 | last complete received byte |
| rx_valid_o | output | 1 | one-cycle strobe marking a new received byte |

## Verification
The start of a new frame and the completion of the received byte can land on the same rising edge. This happens when frames are exactly one slot long and frame sync rises every eight clocks. The bench runs three such back-to-back frames. At each shared edge it expects `rx_valid_o` and `tx_take_o` together. It also expects `rx_byte_o` to carry the previous frame's byte while `dx_o` already shows the MSB of the next transmit byte. Continuous drive with no idle bit between frames shows that the restart does not disturb the slot window.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;

    localparam int unsigned SLOT_BITS = 8;
    localparam int unsigned GAP_BITS  = 2;
    localparam int unsigned POS_BITS  = 6;

    typedef enum logic [1:0] {
        TM_DIRECT    = 2'b00,
        TM_INVERTED  = 2'b01,
        TM_LATE      = 2'b10,
        TM_LATE_ALT  = 2'b11
    } timing_mode_e;

    typedef struct packed {
        logic inverted;
        logic late;
    } edge_plan_t;

    typedef struct packed {
        logic fmt_gap;
        logic want_b2;
        logic companded;
        logic enable;
    } slot_cfg_t;

    function automatic edge_plan_t decode_timing(input logic [1:0] code);
        edge_plan_t p;
        case (timing_mode_e'(code))
            TM_DIRECT:   p = '{inverted: 1'b0, late: 1'b0};
            TM_INVERTED: p = '{inverted: 1'b1, late: 1'b0};
            default:     p = '{inverted: 1'b0, late: 1'b1};
        endcase
        return p;
    endfunction

    function automatic int unsigned slot_first(input slot_cfg_t c,
                                               input int unsigned slot_w,
                                               input int unsigned gap_w);
        if (c.want_b2 && c.companded) begin
            return c.fmt_gap ? (slot_w + gap_w) : slot_w;
        end
        return 0;
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
`timescale 1ns/1ps
module pcm_frame_timer #(
    parameter int unsigned POS_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs_i,
    input  logic             late_i,
    output logic             start_edge_o,
    output logic [POS_W-1:0] pos_o
);
    localparam logic [POS_W-1:0] POS_IDLE = '1;

    logic             fs_q;
    logic             pend_q;
    logic [POS_W-1:0] pos_q;
    logic             fs_rise;

    always_comb begin
        fs_rise      = fs_i & ~fs_q;
        start_edge_o = late_i ? pend_q : fs_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q   <= 1'b0;
            pend_q <= 1'b0;
            pos_q  <= POS_IDLE;
        end else begin
            fs_q   <= fs_i;
            pend_q <= late_i & fs_rise;
            if (start_edge_o) begin
                pos_q <= '0;
            end else if (pos_q != POS_IDLE) begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/pcm_tx_path.sv
`timescale 1ns/1ps
module pcm_tx_path #(
    parameter int unsigned SLOT_W = 8,
    localparam int unsigned IDX_W = $clog2(SLOT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inverted_i,
    input  logic              load_i,
    input  logic [SLOT_W-1:0] byte_i,
    input  logic              active_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic              take_o,
    output logic              dx_o,
    output logic              oe_o
);
    logic [SLOT_W-1:0] hold_q;
    logic              take_q;
    logic              dx_p, oe_p;
    logic              dx_n, oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            take_q <= 1'b0;
        end else begin
            take_q <= load_i;
            if (load_i) begin
                hold_q <= byte_i;
            end
        end
    end

    always_comb begin
        oe_p = active_i;
        dx_p = active_i & hold_q[IDX_W'(SLOT_W-1) - bit_idx_i];
    end

    // half-bit retiming used by the inverted-edge mode
    always_ff @(negedge clk) begin
        if (rst) begin
            dx_n <= 1'b0;
            oe_n <= 1'b0;
        end else begin
            dx_n <= dx_p;
            oe_n <= oe_p;
        end
    end

    assign take_o = take_q;
    assign dx_o   = inverted_i ? dx_n : dx_p;
    assign oe_o   = inverted_i ? oe_n : oe_p;
endmodule

// File: rtl/pcm_rx_path.sv
`timescale 1ns/1ps
module pcm_rx_path #(
    parameter int unsigned SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inverted_i,
    input  logic              dr_i,
    input  logic              active_i,
    input  logic              last_i,
    output logic [SLOT_W-1:0] byte_o,
    output logic              valid_o
);
    logic              dr_mid;
    logic              bit_in;
    logic [SLOT_W-1:0] shift_q;
    logic [SLOT_W-1:0] byte_q;
    logic              valid_q;
    logic [SLOT_W-1:0] shift_nx;

    always_ff @(negedge clk) begin
        if (rst) begin
            dr_mid <= 1'b0;
        end else begin
            dr_mid <= dr_i;
        end
    end

    always_comb begin
        bit_in   = inverted_i ? dr_i : dr_mid;
        shift_nx = {shift_q[SLOT_W-2:0], bit_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            byte_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (active_i) begin
                shift_q <= shift_nx;
                if (last_i) begin
                    byte_q  <= shift_nx;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign byte_o  = byte_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/pcm_voice_port.sv
`timescale 1ns/1ps
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned SLOT_W = SLOT_BITS,
    parameter int unsigned GAP_W  = GAP_BITS,
    parameter int unsigned POS_W  = POS_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_i,
    input  logic [1:0]        mode_i,
    input  logic              fmt_i,
    input  logic              slot_sel_i,
    input  logic              en_i,
    input  logic              comp_i,
    input  logic [SLOT_W-1:0] tx_byte_i,
    output logic              tx_take_o,
    output logic              dx_o,
    output logic              dx_oe_o,
    input  logic              dr_i,
    output logic [SLOT_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);
    localparam int unsigned IDX_W = $clog2(SLOT_W);

    edge_plan_t       plan;
    slot_cfg_t        cfg;
    logic [POS_W-1:0] pos_w;
    logic [POS_W-1:0] first_w;
    logic [POS_W-1:0] offset_w;
    logic             start_edge;
    logic             in_slot;
    logic             last_bit;
    logic [IDX_W-1:0] bit_idx;

    always_comb begin
        plan     = decode_timing(mode_i);
        cfg      = '{fmt_gap: fmt_i, want_b2: slot_sel_i,
                     companded: comp_i, enable: en_i};
        first_w  = POS_W'(slot_first(cfg, SLOT_W, GAP_W));
        offset_w = pos_w - first_w;
        in_slot  = cfg.enable && (pos_w >= first_w) && (offset_w < POS_W'(SLOT_W));
        bit_idx  = offset_w[IDX_W-1:0];
        last_bit = in_slot && (bit_idx == IDX_W'(SLOT_W-1));
    end

    pcm_frame_timer #(.POS_W(POS_W)) timer_i (
        .clk          (clk),
        .rst          (rst),
        .fs_i         (fs_i),
        .late_i       (plan.late),
        .start_edge_o (start_edge),
        .pos_o        (pos_w)
    );

    pcm_tx_path #(.SLOT_W(SLOT_W)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .inverted_i (plan.inverted),
        .load_i     (start_edge),
        .byte_i     (tx_byte_i),
        .active_i   (in_slot),
        .bit_idx_i  (bit_idx),
        .take_o     (tx_take_o),
        .dx_o       (dx_o),
        .oe_o       (dx_oe_o)
    );

    pcm_rx_path #(.SLOT_W(SLOT_W)) rx_i (
        .clk        (clk),
        .rst        (rst),
        .inverted_i (plan.inverted),
        .dr_i       (dr_i),
        .active_i   (in_slot),
        .last_i     (last_bit),
        .byte_o     (rx_byte_o),
        .valid_o    (rx_valid_o)
    );
endmodule

// File: rtl/pcm_voice_port_chk.sv
`timescale 1ns/1ps
module pcm_voice_port_chk #(
    parameter int unsigned POS_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             fs_i,
    input logic [1:0]       mode_i,
    input logic             en_i,
    input logic             tx_take_o,
    input logic             dx_oe_o,
    input logic             rx_valid_o,
    input logic [POS_W-1:0] pos_i
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dx_oe_o && !rx_valid_o && !tx_take_o));   // R1

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);                                 // R9

    AST_RX_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> $past(en_i));                                 // R8

    AST_TAKE_AT_BIT0: assert property (@(posedge clk) disable iff (rst)
        tx_take_o |-> (pos_i == '0));                                // R10

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tx_take_o |=> !tx_take_o);                                   // R10

    AST_HELD_FS_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_i == 2'b00 && fs_i && $past(fs_i)) |=> !tx_take_o); // R11
endmodule

bind pcm_voice_port pcm_voice_port_chk #(.POS_W(POS_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .fs_i       (fs_i),
    .mode_i     (mode_i),
    .en_i       (en_i),
    .tx_take_o  (tx_take_o),
    .dx_oe_o    (dx_oe_o),
    .rx_valid_o (rx_valid_o),
    .pos_i      (pos_w)
);

// File: tb/pcm_voice_port_tb.sv
`timescale 1ns/1ps
module pcm_voice_port_tb_top;

    typedef struct packed {
        logic [1:0] mode;
        logic       fmt;
        logic       sel;
        logic       comp;
        logic       en;
        logic [7:0] tx;
        logic [7:0] rx;
        logic [4:0] first;
        logic       lag;
    } vec_t;

    // mode, fmt, sel, comp, en, tx, rx, expected first slot bit, expected start lag
    localparam vec_t VECS [0:8] = '{
        '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h3C, 5'd0,  1'b0},
        '{2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 8'h96, 8'hC3, 5'd8,  1'b0},
        '{2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h81, 8'h7E, 5'd10, 1'b0},
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hE1, 5'd0,  1'b0},
        '{2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 8'h33, 8'h0F, 5'd10, 1'b0},
        '{2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h99, 5'd8,  1'b1},
        '{2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h6C, 8'h24, 5'd10, 1'b1},
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h18, 8'h42, 5'd0,  1'b0},
        '{2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 5'd0,  1'b1}
    };

    localparam logic [7:0] BB_TX [0:2] = '{8'hC9, 8'h17, 8'hE4};
    localparam logic [7:0] BB_RX [0:2] = '{8'h2B, 8'hD6, 8'h70};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fs_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       fmt_i = 1'b0;
    logic       slot_sel_i = 1'b0;
    logic       en_i = 1'b0;
    logic       comp_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic       tx_take_o;
    logic       dx_o;
    logic       dx_oe_o;
    logic       dr_i = 1'b0;
    logic [7:0] rx_byte_o;
    logic       rx_valid_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pcm_voice_port dut_i (
        .clk        (clk),
        .rst        (rst),
        .fs_i       (fs_i),
        .mode_i     (mode_i),
        .fmt_i      (fmt_i),
        .slot_sel_i (slot_sel_i),
        .en_i       (en_i),
        .comp_i     (comp_i),
        .tx_byte_i  (tx_byte_i),
        .tx_take_o  (tx_take_o),
        .dx_o       (dx_o),
        .dx_oe_o    (dx_oe_o),
        .dr_i       (dr_i),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic in_win(input int b, input int first, input logic en);
        return en && (b >= first) && (b < first + 8);
    endfunction

    function automatic string tag_of(input vec_t v);
        if (!v.en)              return "R8";
        if (!v.comp)            return "R7";
        if (v.mode == 2'b01)    return "R4";
        if (v.mode[1])          return "R3";
        if (v.first == 5'd10)   return "R6";
        if (v.first == 5'd8)    return "R5";
        return "R2";
    endfunction

    task automatic run_frame(input vec_t v, input bit perturb, input bit held);
        int    first = int'(v.first);
        string tag   = perturb ? "R10" : tag_of(v);
        string ttag  = held ? "R11" : "R10";
        @(posedge clk); #1;
        mode_i = v.mode; fmt_i = v.fmt; slot_sel_i = v.sel;
        comp_i = v.comp; en_i = v.en; tx_byte_i = v.tx; fs_i = 1'b1;
        for (int cyc = 0; cyc < 28; cyc++) begin
            int b;
            @(posedge clk); #1;
            b = cyc - int'(v.lag);
            if (v.mode == 2'b01)
                chk("R4", "oe before mid-bit edge", dx_oe_o, in_win(b - 1, first, v.en));
            fs_i = held || (cyc < 2);
            if (perturb && b == 1) tx_byte_i = ~v.tx;
            dr_i = in_win(b, first, 1'b1) ? v.rx[7 - (b - first)] : 1'b0;
            #2;
            chk(tag, "oe", dx_oe_o, in_win(b, first, v.en));
            if (in_win(b, first, v.en))
                chk(tag, "dx bit", dx_o, v.tx[7 - (b - first)]);
            chk(ttag, "take", tx_take_o, b == 0);
            chk("R9", "rx strobe", rx_valid_o, v.en && (b == first + 8));
            if (v.en && b == first + 8)
                chk("R9", "rx byte", rx_byte_o, v.rx);
        end
        fs_i = 1'b0;
    endtask

    task automatic run_back_to_back();
        @(posedge clk); #1;
        mode_i = 2'b00; fmt_i = 1'b0; slot_sel_i = 1'b0;
        comp_i = 1'b1; en_i = 1'b1; tx_byte_i = BB_TX[0]; fs_i = 1'b1;
        for (int cyc = 0; cyc < 26; cyc++) begin
            int f = cyc / 8;
            int k = cyc % 8;
            @(posedge clk); #1;
            fs_i = ((cyc + 1) % 8 == 0) && (cyc + 1 <= 16);
            if (k == 7 && cyc < 16) tx_byte_i = BB_TX[f + 1];
            dr_i = (cyc < 24) ? BB_RX[f][7 - k] : 1'b0;
            #2;
            chk("R2", "back-to-back oe", dx_oe_o, cyc < 24);
            if (cyc < 24) chk("R10", "back-to-back dx", dx_o, BB_TX[f][7 - k]);
            chk("R10", "back-to-back take", tx_take_o, (k == 0) && (cyc <= 16));
            chk("R9", "back-to-back strobe", rx_valid_o, (k == 0) && (cyc >= 8) && (cyc <= 24));
            if (k == 0 && cyc >= 8 && cyc <= 24)
                chk("R9", "back-to-back byte", rx_byte_o, BB_RX[f - 1]);
        end
        fs_i = 1'b0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog all requirements: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "oe in reset", dx_oe_o, 1'b0);
        chk("R1", "strobe in reset", rx_valid_o, 1'b0);
        chk("R1", "byte in reset", rx_byte_o, 8'h00);
        chk("R1", "take in reset", tx_take_o, 1'b0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1", "oe after reset", dx_oe_o, 1'b0);
        chk("R1", "strobe after reset", rx_valid_o, 1'b0);

        for (int i = 0; i < 9; i++) run_frame(VECS[i], 1'b0, 1'b0);

        run_frame('{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC6, 8'h5D, 5'd0, 1'b0}, 1'b1, 1'b0);
        run_frame('{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hA1, 5'd0, 1'b0}, 1'b0, 1'b1);
        run_back_to_back();

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule